// File: doc/BRIEF.md
# Wrapping Instruction Address Generator

This block produces the fetch address for a small sequencer whose program sits in a 32-slot instruction store. On every enabled cycle it moves the address forward by one, or sends it to a jump destination when the decode logic reports a taken branch. The sequencer's loop is bounded by a programmable window: once the instruction at the window's upper address has run, the next fetch comes from the window's lower address instead of running on to the end of the store.

The two window bounds sit in a small configuration register pair written through a load strobe. After reset the upper bound is the last slot and the lower bound is slot zero, so an unconfigured sequencer cycles through the whole store. A restart input returns the address to the lower bound at once, whatever else is requested in the same cycle. A stall input freezes the address. The reset input clears asynchronously and is released in step with the clock through a short synchroniser chain.

Top module: `pc_wrap_counter`

## Requirements
- R1: While reset is active, and on the first clock after release, the address is 0, the upper bound is 31 and the lower bound is 0. With no configuration write, an address of 31 is followed by 0.
- R2: With restart, stall and jump all low and the address not equal to the upper bound, the next address is the current address plus 1, rolling over from 31 to 0.
- R3: With restart, stall and jump all low and the address equal to the upper bound, the next address is the lower bound.
- R4: With restart and stall low and jump high, the next address is the jump target, including when the current address equals the upper bound.
- R5: With restart low and stall high, the address keeps its value; a jump request or a window boundary in that cycle has no effect.
- R6: With restart high, the next address is the lower bound, regardless of stall, jump or the current address.
- R7: When the upper bound is below the lower bound, the address still steps by 1 through the rollover from 31 to 0 until it meets the upper bound, then returns to the lower bound.
- R8: A cycle with the configuration strobe high loads both bounds; the new values govern the address update from the following cycle onward.
- R9: When the upper bound equals the lower bound, an unstalled non-jumping sequencer stays at that single address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| restart | input | 1 | Return to the lower window bound next cycle |
| stall | input | 1 | Hold the current address |
| jmp_take | input | 1 | Current instruction is a taken jump |
| jmp_tgt | input | 5 | Jump destination address |
| cfg_we | input | 1 | Load strobe for the window bounds |
| cfg_top | input | 5 | New upper window bound |
| cfg_bot | input | 5 | New lower window bound |
| pc | output | 5 | Address of the instruction to fetch |

## Verification
The bench builds the block with its default five-bit address and two-stage reset synchroniser, so the whole 32-slot store is reachable in a handful of cycles and the rollover from 31 to 0 is exercised both inside the reset-default window and inside an inverted window. With these sizes the degenerate one-slot window, a jump issued exactly at the upper bound and a restart colliding with stall and jump can all be reached directly. An asynchronous reset in mid-run then shows the bounds returning to their defaults.

// File: rtl/pc_wrap_pkg.sv
package pc_wrap_pkg;

  // Source chosen for the next address, in priority order.
  typedef enum logic [2:0] {
    SEL_RESTART = 3'd0,
    SEL_HOLD    = 3'd1,
    SEL_JUMP    = 3'd2,
    SEL_WRAP    = 3'd3,
    SEL_INC     = 3'd4
  } pc_sel_e;

endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Stage 0 takes a constant one; later stages shift it along.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pc_wrap_cfg.sv
module pc_wrap_cfg #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] top_d,
  input  logic [AW-1:0] bot_d,
  output logic [AW-1:0] top_q,
  output logic [AW-1:0] bot_q
);

  localparam logic [AW-1:0] TOP_RST = {AW{1'b1}};
  localparam logic [AW-1:0] BOT_RST = '0;

  logic [AW-1:0] top_nx;
  logic [AW-1:0] bot_nx;

  always_comb begin
    top_nx = top_q;
    bot_nx = bot_q;
    if (we) begin
      top_nx = top_d;
      bot_nx = bot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= TOP_RST;
      bot_q <= BOT_RST;
    end else if (we) begin
      top_q <= top_nx;
      bot_q <= bot_nx;
    end
  end

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_wrap_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          restart,
  input  logic          stall,
  input  logic          jmp_take,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] top_q,
  output pc_sel_e       sel
);

  always_comb begin
    if (restart)             sel = SEL_RESTART;
    else if (stall)          sel = SEL_HOLD;
    else if (jmp_take)       sel = SEL_JUMP;
    else if (pc_q == top_q)  sel = SEL_WRAP;
    else                     sel = SEL_INC;
  end

endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pc_wrap_pkg::*;
#(
  parameter int AW = 5
) (
  input  pc_sel_e       sel,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] bot_q,
  input  logic [AW-1:0] jmp_tgt,
  output logic [AW-1:0] pc_nx,
  output logic          pc_en
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    pc_en = 1'b1;
    unique case (sel)
      SEL_RESTART: pc_nx = bot_q;
      SEL_JUMP:    pc_nx = jmp_tgt;
      SEL_WRAP:    pc_nx = bot_q;
      SEL_INC:     pc_nx = pc_q + ONE;
      default: begin
        pc_nx = pc_q;
        pc_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pc_wrap_counter.sv
module pc_wrap_counter
  import pc_wrap_pkg::*;
#(
  parameter int AW         = 5,
  parameter int SYNC_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          stall,
  input  logic          jmp_take,
  input  logic [AW-1:0] jmp_tgt,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_top,
  input  logic [AW-1:0] cfg_bot,
  output logic [AW-1:0] pc
);

  logic          rst_sync_n;
  logic [AW-1:0] top_q;
  logic [AW-1:0] bot_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_nx;
  logic          pc_en;
  pc_sel_e       sel;

  pc_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pc_wrap_cfg #(.AW(AW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .top_d (cfg_top),
    .bot_d (cfg_bot),
    .top_q (top_q),
    .bot_q (bot_q)
  );

  pc_next_sel #(.AW(AW)) u_sel (
    .restart  (restart),
    .stall    (stall),
    .jmp_take (jmp_take),
    .pc_q     (pc_q),
    .top_q    (top_q),
    .sel      (sel)
  );

  pc_next_mux #(.AW(AW)) u_mux (
    .sel     (sel),
    .pc_q    (pc_q),
    .bot_q   (bot_q),
    .jmp_tgt (jmp_tgt),
    .pc_nx   (pc_nx),
    .pc_en   (pc_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= '0;
    else if (pc_en)   pc_q <= pc_nx;
  end

  assign pc = pc_q;

endmodule

// File: rtl/pc_wrap_counter_chk.sv
module pc_wrap_counter_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          restart,
  input logic          stall,
  input logic          jmp_take,
  input logic [AW-1:0] jmp_tgt,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_top,
  input logic [AW-1:0] cfg_bot,
  input logic [AW-1:0] top_q,
  input logic [AW-1:0] bot_q,
  input logic [AW-1:0] pc
);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && !stall && !jmp_take && pc != top_q) |=> (pc == $past(pc) + 1'b1));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && !stall && !jmp_take && pc == top_q) |=> (pc == $past(bot_q)));

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && !stall && jmp_take) |=> (pc == $past(jmp_tgt)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!restart && stall) |=> $stable(pc));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |=> (pc == $past(bot_q)));

  assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> (top_q == $past(cfg_top) && bot_q == $past(cfg_bot)));

  assert_cfg_keep_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> ($stable(top_q) && $stable(bot_q)));

endmodule

bind pc_wrap_counter pc_wrap_counter_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .restart    (restart),
  .stall      (stall),
  .jmp_take   (jmp_take),
  .jmp_tgt    (jmp_tgt),
  .cfg_we     (cfg_we),
  .cfg_top    (cfg_top),
  .cfg_bot    (cfg_bot),
  .top_q      (top_q),
  .bot_q      (bot_q),
  .pc         (pc)
);

// File: tb/test_pc_wrap_counter.sv
`timescale 1ns/1ps
module test_pc_wrap_counter;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          restart, stall, jmp_take, cfg_we;
  logic [AW-1:0] jmp_tgt, cfg_top, cfg_bot;
  logic [AW-1:0] pc;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pc_wrap_counter #(.AW(AW)) i_pc_wrap_counter (
    .clk (clk), .rst_n (rst_n), .restart (restart), .stall (stall),
    .jmp_take (jmp_take), .jmp_tgt (jmp_tgt), .cfg_we (cfg_we),
    .cfg_top (cfg_top), .cfg_bot (cfg_bot), .pc (pc)
  );

  // Vector: {restart, stall, jump, target[4:0], expected pc[4:0]}
  // Runs with the reset-default window (upper 31, lower 0) from pc 0.
  localparam int NV = 13;
  localparam logic [12:0] VEC [NV] = '{
    {3'b000, 5'd0,  5'd1},   // R2 step
    {3'b000, 5'd0,  5'd2},   // R2 step
    {3'b010, 5'd0,  5'd2},   // R5 hold
    {3'b011, 5'd9,  5'd2},   // R5 jump ignored under stall
    {3'b001, 5'd29, 5'd29},  // R4 jump
    {3'b000, 5'd0,  5'd30},  // R2
    {3'b000, 5'd0,  5'd31},  // R2
    {3'b000, 5'd0,  5'd0},   // R1/R3 default window wraps 31 -> 0
    {3'b001, 5'd31, 5'd31},  // R4
    {3'b001, 5'd7,  5'd7},   // R4 jump beats wrap at upper bound
    {3'b110, 5'd0,  5'd0},   // R6 restart beats stall
    {3'b101, 5'd5,  5'd0},   // R6 restart beats jump
    {3'b000, 5'd0,  5'd1}    // R2
  };

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (pc !== exp) begin
      fails++;
      $display("FAIL %s: pc=%0d expected=%0d", req, pc, exp);
    end
  endtask

  // Drive one cycle from a negedge, land on the next negedge.
  task automatic cyc(input logic rs, input logic st, input logic jp,
                     input logic [AW-1:0] tg);
    restart = rs; stall = st; jmp_take = jp; jmp_tgt = tg;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0; stall = 1'b0; jmp_take = 1'b0;
  endtask

  task automatic set_win(input logic [AW-1:0] t, input logic [AW-1:0] b);
    cfg_we = 1'b1; cfg_top = t; cfg_bot = b;
    cyc(1'b0, 1'b1, 1'b0, '0);
    cfg_we = 1'b0;
  endtask

  task automatic run(input string req, input int n, input logic [AW-1:0] e0,
                     input logic [AW-1:0] e1, input logic [AW-1:0] e2,
                     input logic [AW-1:0] e3, input logic [AW-1:0] e4,
                     input logic [AW-1:0] e5);
    logic [AW-1:0] ex [6];
    ex = '{e0, e1, e2, e3, e4, e5};
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, 1'b0, '0);
      check(req, ex[i]);
    end
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; stall = 1'b0; jmp_take = 1'b0;
    jmp_tgt = '0; cfg_we = 1'b0; cfg_top = '0; cfg_bot = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 5'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, '0);
    check("R1 after release", 5'd0);

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][12], VEC[v][11], VEC[v][10], VEC[v][9:5]);
      check($sformatf("R2-6 vector %0d", v), VEC[v][4:0]);
    end

    // R8: new window takes effect; R3 wrap in it
    set_win(5'd12, 5'd10);
    check("R8 stall during write", 5'd1);
    cyc(1'b1, 1'b0, 1'b0, '0);
    check("R8 restart to new lower", 5'd10);
    run("R3 small window", 4, 5'd11, 5'd12, 5'd10, 5'd11, 5'd0, 5'd0);

    // R7: inverted window across the rollover
    set_win(5'd2, 5'd29);
    cyc(1'b1, 1'b0, 1'b0, '0);
    check("R7 restart", 5'd29);
    run("R7 inverted", 6, 5'd30, 5'd31, 5'd0, 5'd1, 5'd2, 5'd29);
    cyc(1'b0, 1'b1, 1'b1, 5'd4);
    check("R5 hold in inverted window", 5'd29);

    // R9: one-slot window
    set_win(5'd6, 5'd6);
    cyc(1'b1, 1'b0, 1'b0, '0);
    check("R9 restart", 5'd6);
    run("R9 single slot", 3, 5'd6, 5'd6, 5'd6, 5'd0, 5'd0, 5'd0);

    // R1: asynchronous reset mid-run restores default window
    #2 rst_n = 1'b0;
    #1 check("R1 async clear", 5'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, '0);
    run("R1 default upper restored", 6, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6);
    run("R1 passes old upper bound", 2, 5'd7, 5'd8, 5'd0, 5'd0, 5'd0, 5'd0);
    cyc(1'b0, 1'b0, 1'b1, 5'd31);
    check("R4 jump to 31", 5'd31);
    run("R1 default lower", 1, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule